// File: doc/BRIEF.md
# Line-Count Measurement and HSYNC Regeneration

This block runs in the pixel clock domain. It watches raw horizontal and vertical sync and counts the horizontal sync edges that arrive in each vertical period. At every vertical sync edge it stores the finished count in a readable register and starts counting again. The stored count is 12 bits wide. Software reads it as two bytes, and reading the high byte freezes a copy of the low byte, so a read of both bytes gives values from the same frame.

The block also builds a new horizontal sync pulse. The pulse starts on the clock after each rising edge of the incoming HSYNC and lasts a programmable number of pixel clocks. The regenerated HSYNC, the delayed VSYNC, display-enable and odd/even field each pass through their own polarity bit before they leave the block. A small register bus with a 2-bit address and separate write and read strobes configures the block and reads it back.

Top module: `sync_measure_regen`

## Requirements
- R1: On each rising edge of `vs_in`, the block stores the number of `hs_in` rising edges seen since the previous `vs_in` rising edge. Address 0 reads bits [11:8] of the stored count in bits [3:0], with zeros in bits [7:4]. An `hs_in` edge that falls in the same clock as the `vs_in` edge counts toward the new frame.
- R2: The running line count saturates at 4095. A frame with more lines reports 4095, so address 0 reads 0x0F and the low byte reads 0xFF.
- R3: A read strobe at address 0 copies the low 8 bits of the stored count into a snapshot. Address 1 returns that snapshot, and a later frame update does not change it.
- R4: After reset the stored count is 0, the snapshot is 0, the width register at address 2 reads 32, and the polarity register at address 3 reads 0x0F.
- R5: A rising edge of `hs_in` starts the regenerated pulse on the next clock. The pulse lasts exactly the number of pixel clocks held in the width register at that edge.
- R6: A width value of 0 gives a pulse one pixel clock long.
- R7: The polarity register sets how each output is driven. Bit 3 is for HSYNC, bit 2 for VSYNC, bit 1 for display-enable and bit 0 for field. A bit of 1 drives the signal active high and a bit of 0 inverts it.
- R8: `vs_out`, `de_out` and `fld_out` follow `vs_in`, `de_in` and `fld_in` one clock later, after the polarity is applied.
- R9: Writes to address 0 or address 1 have no effect on the stored count or on the snapshot.
- R10: A new `hs_in` rising edge while a pulse is still active restarts the full programmed width from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Raw horizontal sync, active high |
| vs_in | input | 1 | Raw vertical sync, active high |
| de_in | input | 1 | Raw display-enable |
| fld_in | input | 1 | Raw odd/even field |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (takes the snapshot at address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| hs_out | output | 1 | Regenerated HSYNC after polarity |
| vs_out | output | 1 | Delayed VSYNC after polarity |
| de_out | output | 1 | Delayed display-enable after polarity |
| fld_out | output | 1 | Delayed field after polarity |

## Verification
The counter is run with frames of 5, 7, 10 and 300 lines and with one frame of 4100 lines. These show whether the edge that ends a frame is counted, whether the high byte is in the right place, and whether the count wraps or saturates. The HSYNC regenerator is run with widths of 5, 0, 200 and the reset value. Isolated edges and edges closer together than the pulse width tell the minimum-width rule apart from the restart rule. The polarity patterns all-high, all-low and alternating (0xA) show whether any output uses another output's polarity bit.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {
    RA_CNT_HI   = 2'd0,
    RA_CNT_LO   = 2'd1,
    RA_HS_WIDTH = 2'd2,
    RA_POLARITY = 2'd3
  } reg_addr_e;

  localparam int POL_N   = 4;
  localparam int POL_HS  = 3;
  localparam int POL_VS  = 2;
  localparam int POL_DE  = 1;
  localparam int POL_FLD = 0;

  // Output level for a given polarity bit: 1 keeps the level, 0 inverts it.
  function automatic logic pol_apply(input logic level, input logic pol);
    return pol ? level : ~level;
  endfunction

endpackage

// File: rtl/smr_line_counter.sv
module smr_line_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic             vs_rise,
  output logic [CNT_W-1:0] work_cnt,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_cnt <= '0;
      count_q  <= '0;
    end else if (vs_rise) begin
      count_q  <= work_cnt;
      work_cnt <= {{(CNT_W-1){1'b0}}, hs_rise};
    end else if (hs_rise) begin
      work_cnt <= sat_inc(work_cnt);
    end
  end

endmodule

// File: rtl/smr_hs_regen.sv
module smr_hs_regen #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic [WID_W-1:0] width,
  output logic             pulse_on,
  output logic [WID_W-1:0] left_q
);

  // A zero width still produces a one-clock pulse.
  function automatic logic [WID_W-1:0] eff_width(input logic [WID_W-1:0] w);
    return (w == '0) ? {{(WID_W-1){1'b0}}, 1'b1} : w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (hs_rise) begin
      left_q <= eff_width(width);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pulse_on = (left_q != '0);

endmodule

// File: rtl/smr_regs.sv
module smr_regs
  import smr_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int WID_W     = 8,
  parameter int WID_RESET = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic [CNT_W-1:0] count,
  output logic [7:0]       rdata,
  output logic [WID_W-1:0] width,
  output logic [POL_N-1:0] pol,
  output logic [7:0]       snap_lo
);

  localparam logic [WID_W-1:0] WID_INIT = WID_W'(WID_RESET);

  logic [7:0] hi_byte;
  assign hi_byte = 8'(count >> 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width   <= WID_INIT;
      pol     <= '1;
      snap_lo <= '0;
    end else begin
      if (wr) begin
        case (addr)
          RA_HS_WIDTH: width <= WID_W'(wdata);
          RA_POLARITY: pol   <= wdata[POL_N-1:0];
          default: ;
        endcase
      end
      if (rd && addr == RA_CNT_HI) snap_lo <= count[7:0];
    end
  end

  always_comb begin
    case (addr)
      RA_CNT_HI:   rdata = hi_byte;
      RA_CNT_LO:   rdata = snap_lo;
      RA_HS_WIDTH: rdata = 8'(width);
      default:     rdata = 8'(pol);
    endcase
  end

endmodule

// File: rtl/sync_measure_regen.sv
module sync_measure_regen
  import smr_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int WID_W     = 8,
  parameter int WID_RESET = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_in,
  input  logic       vs_in,
  input  logic       de_in,
  input  logic       fld_in,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       hs_out,
  output logic       vs_out,
  output logic       de_out,
  output logic       fld_out
);

  logic             hs_q, vs_q, de_q, fld_q;
  logic             hs_rise, vs_rise;
  logic [CNT_W-1:0] work_cnt, count_q;
  logic [WID_W-1:0] width, left_q;
  logic [POL_N-1:0] pol;
  logic [7:0]       snap_lo;
  logic             pulse_on;
  logic [POL_N-1:0] level_vec, out_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      de_q  <= 1'b0;
      fld_q <= 1'b0;
    end else begin
      hs_q  <= hs_in;
      vs_q  <= vs_in;
      de_q  <= de_in;
      fld_q <= fld_in;
    end
  end

  assign hs_rise = hs_in & ~hs_q;
  assign vs_rise = vs_in & ~vs_q;

  smr_line_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_rise  (hs_rise),
    .vs_rise  (vs_rise),
    .work_cnt (work_cnt),
    .count_q  (count_q)
  );

  smr_hs_regen #(.WID_W(WID_W)) u_regen (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_rise  (hs_rise),
    .width    (width),
    .pulse_on (pulse_on),
    .left_q   (left_q)
  );

  smr_regs #(.CNT_W(CNT_W), .WID_W(WID_W), .WID_RESET(WID_RESET)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .count   (count_q),
    .rdata   (reg_rdata),
    .width   (width),
    .pol     (pol),
    .snap_lo (snap_lo)
  );

  always_comb begin
    level_vec          = '0;
    level_vec[POL_HS]  = pulse_on;
    level_vec[POL_VS]  = vs_q;
    level_vec[POL_DE]  = de_q;
    level_vec[POL_FLD] = fld_q;
  end

  for (genvar i = 0; i < POL_N; i++) begin : g_pol
    assign out_vec[i] = pol_apply(level_vec[i], pol[i]);
  end

  assign hs_out  = out_vec[POL_HS];
  assign vs_out  = out_vec[POL_VS];
  assign de_out  = out_vec[POL_DE];
  assign fld_out = out_vec[POL_FLD];

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_rise,
  input logic             vs_rise,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] work_cnt,
  input logic [CNT_W-1:0] count_q,
  input logic [7:0]       snap_lo,
  input logic             pulse_on,
  input logic [WID_W-1:0] left_q
);

  p_frame_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> count_q == $past(work_cnt));

  p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise && (&work_cnt)) |=> (&work_cnt));

  p_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0) |=> snap_lo == $past(count_q[7:0]));

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> pulse_on);

  p_pulse_decay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_on && !hs_rise) |=> left_q == WID_W'($past(left_q) - 1'b1));

endmodule

bind sync_measure_regen smr_checker #(.CNT_W(CNT_W), .WID_W(WID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hs_rise  (hs_rise),
  .vs_rise  (vs_rise),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .work_cnt (work_cnt),
  .count_q  (count_q),
  .snap_lo  (snap_lo),
  .pulse_on (pulse_on),
  .left_q   (left_q)
);

// File: tb/sync_measure_regen_test.sv
module sync_measure_regen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_hs = 0, d_vs = 0, d_de = 0, d_fld = 0;
  logic       d_wr = 0, d_rd = 0;
  logic [1:0] d_addr = 0;
  logic [7:0] d_wdata = 0;
  logic [7:0] reg_rdata;
  logic       hs_out, vs_out, de_out, fld_out;

  int n_run = 0, n_fail = 0;

  // reference model state
  int       m_work = 0, m_count = 0, m_left = 0, m_w = 32, m_snap = 0;
  bit [3:0] m_pol = 4'hF;
  bit       m_hsp = 0, m_vsq = 0, m_deq = 0, m_fq = 0;

  always #2.5 clk = ~clk;

  sync_measure_regen uut (
    .clk(clk), .rst_n(rst_n), .hs_in(d_hs), .vs_in(d_vs), .de_in(d_de),
    .fld_in(d_fld), .reg_wr(d_wr), .reg_rd(d_rd), .reg_addr(d_addr),
    .reg_wdata(d_wdata), .reg_rdata(reg_rdata), .hs_out(hs_out),
    .vs_out(vs_out), .de_out(de_out), .fld_out(fld_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit lvl(input bit v, input bit p);
    return p ? v : !v;
  endfunction

  // One clock: model follows the edge, then outputs are compared.
  task automatic step();
    bit hr, vr;
    @(posedge clk);
    hr = d_hs && !m_hsp;
    vr = d_vs && !m_vsq;
    m_hsp = d_hs;
    if (d_rd && d_addr == 2'd0) m_snap = m_count % 256;
    if (hr) m_left = (m_w == 0) ? 1 : m_w;
    else if (m_left > 0) m_left--;
    if (vr) begin
      m_count = m_work;
      m_work  = hr ? 1 : 0;
    end else if (hr && m_work < 4095) m_work++;
    if (d_wr && d_addr == 2'd2) m_w = d_wdata;
    if (d_wr && d_addr == 2'd3) m_pol = d_wdata[3:0];
    m_vsq = d_vs; m_deq = d_de; m_fq = d_fld;
    #1;
    n_run++;
    if (hs_out !== lvl(m_left > 0, m_pol[3]) || vs_out !== lvl(m_vsq, m_pol[2]) ||
        de_out !== lvl(m_deq, m_pol[1]) || fld_out !== lvl(m_fq, m_pol[0])) begin
      n_fail++;
      $display("FAIL R5/R7/R8 outs act=%b%b%b%b exp=%b%b%b%b", hs_out, vs_out, de_out,
               fld_out, lvl(m_left > 0, m_pol[3]), lvl(m_vsq, m_pol[2]),
               lvl(m_deq, m_pol[1]), lvl(m_fq, m_pol[0]));
    end
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string tag);
    d_addr = a; d_rd = 1'b1;
    #1;
    chk(tag, reg_rdata, exp);
    step();
    d_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    d_addr = a; d_wdata = v; d_wr = 1'b1;
    step();
    d_wr = 1'b0;
  endtask

  task automatic line(input int hi, input int period);
    d_hs = 1'b1;
    for (int i = 0; i < hi; i++) step();
    d_hs = 1'b0;
    for (int i = hi; i < period; i++) step();
  endtask

  task automatic frame(input int lines, input int hi, input int period);
    d_vs = 1'b1; step(); step();
    d_vs = 1'b0;
    for (int i = 0; i < lines; i++) line(hi, period);
  endtask

  task automatic measure(input int exp, input string tag);
    int n = 0;
    d_hs = 1'b1; step(); d_hs = 1'b0;
    while (hs_out && n < 300) begin n++; step(); end
    for (int i = 0; i < 4; i++) step();
    chk(tag, n, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R4 reset values
    rd_check(2'd0, 0, "R4 count hi");
    rd_check(2'd1, 0, "R4 snapshot");
    rd_check(2'd2, 32, "R4 width");
    rd_check(2'd3, 15, "R4 polarity");

    // R1 basic counts
    frame(5, 3, 12);
    frame(7, 3, 12);
    rd_check(2'd0, 0, "R1 hi 5");
    rd_check(2'd1, 5, "R1 lo 5");
    frame(300, 2, 6);
    d_vs = 1'b1; step(); d_vs = 1'b0; step();
    rd_check(2'd0, 1, "R1 hi 300");
    rd_check(2'd1, 8'h2C, "R1 lo 300");

    // R1 coincident edge: vs and hs rise together, 4 more lines follow
    d_vs = 1'b1; d_hs = 1'b1; step(); step(); d_vs = 1'b0; d_hs = 1'b0; step();
    for (int i = 0; i < 4; i++) line(2, 5);
    d_vs = 1'b1; step(); d_vs = 1'b0; step();
    rd_check(2'd0, 0, "R1 coincident hi");
    rd_check(2'd1, 5, "R1 coincident lo");

    // R3 snapshot survives a frame update
    frame(300, 2, 6);
    d_vs = 1'b1; step(); d_vs = 1'b0; step();
    rd_check(2'd0, 1, "R3 hi");
    for (int i = 0; i < 10; i++) line(2, 6);
    d_vs = 1'b1; step(); d_vs = 1'b0; step();
    rd_check(2'd1, 8'h2C, "R3 held lo");
    rd_check(2'd0, 0, "R3 new hi");
    rd_check(2'd1, 10, "R3 new lo");

    // R9 writes to read-only addresses
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    rd_check(2'd0, 0, "R9 hi");
    rd_check(2'd1, 10, "R9 lo");

    // R5, R6, R10 pulse width
    for (int i = 0; i < 40; i++) step();
    measure(32, "R5 default width");
    wr_reg(2'd2, 8'd5);
    measure(5, "R5 width 5");
    wr_reg(2'd2, 8'd0);
    measure(1, "R6 width 0");
    wr_reg(2'd2, 8'd5);
    n = 0;
    d_hs = 1'b1; step(); if (hs_out) n++;
    d_hs = 1'b0; step(); if (hs_out) n++;
    step(); if (hs_out) n++;
    d_hs = 1'b1; step(); d_hs = 1'b0;
    while (hs_out && n < 300) begin n++; step(); end
    chk("R10 retrigger", n, 8);
    wr_reg(2'd2, 8'd200);
    for (int i = 0; i < 6; i++) line(3, 12);
    for (int i = 0; i < 210; i++) step();

    // R8 one-cycle delay, R7 polarity
    wr_reg(2'd2, 8'd4);
    d_de = 1'b1;
    #1 chk("R8 de not yet", de_out, 0);
    step();
    chk("R8 de after one clock", de_out, 1);
    d_de = 1'b0; step();
    wr_reg(2'd3, 8'h00);
    d_vs = 1'b1; d_de = 1'b1; d_fld = 1'b1; step();
    chk("R7 vs low-active", vs_out, 0);
    chk("R7 de low-active", de_out, 0);
    chk("R7 fld low-active", fld_out, 0);
    chk("R7 hs idle high", hs_out, 1);
    d_vs = 1'b0; d_de = 1'b0; d_fld = 1'b0; step();
    wr_reg(2'd3, 8'h0A);
    d_vs = 1'b1; d_de = 1'b1; d_fld = 1'b1; step();
    chk("R7 vs pol 0xA", vs_out, 1 ^ 1);
    chk("R7 de pol 0xA", de_out, 1);
    chk("R7 fld pol 0xA", fld_out, 0);
    d_vs = 1'b0; d_de = 1'b0; d_fld = 1'b0;
    frame(3, 2, 10);
    wr_reg(2'd3, 8'h0F);

    // R2 saturation
    frame(4100, 1, 2);
    d_vs = 1'b1; step(); d_vs = 1'b0; step();
    rd_check(2'd0, 8'h0F, "R2 hi sat");
    rd_check(2'd1, 8'hFF, "R2 lo sat");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule